// File: doc/BRIEF.md
# Interrupt Priority Stack Controller

This block keeps a processor's interrupt priority state and decides when a pending request may interrupt the program. The current level is a 2-bit value in the low bits of a wider register. The upper bits hold earlier levels, so the register works as a small stack. The decoder reports each instruction as it retires, together with what that instruction does to the priority state. The operations are: push a new level, restore the previous level, and load the whole register from a byte popped off the memory stack. That pop happens either as a plain load or as the first half of a return-from-interrupt.

The decoder also marks some retiring instructions as privileged. These include stack-pointer loads, bank-register loads, bit tests of memory and priority-register loads. After such an instruction, the next instruction boundary is protected, so the instruction that follows always runs before any interrupt. This keeps pairs such as "load stack pointer, then load stack segment" and "test semaphore bit, then set it" atomic. It also makes sure a return placed after a priority pop executes before the stack can grow again.

Requests arrive with a 2-bit level. At an instruction boundary with no protection in force, a request is taken when its level is strictly above the current level. Taking it pushes the request's level onto the priority stack in the same cycle as the take pulse.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous reset clears the priority register to 0x00 and clears the shadow flag. While reset is held, the take output stays low.
- R2: A set operation with level n retires, where n is one of the four 2-bit codes 0 to 3. The priority register then shifts left by two bits and n goes into bits 1:0. The old bits 7:6 are dropped.
- R3: A restore operation retires. The priority register then rotates right by two bits: bits 1:0 move to bits 7:6 and every other pair moves down one slot.
- R4: A priority-load operation or a return-from-interrupt retires. The priority register then takes the popped byte unchanged. If several operations are flagged together, the load/return has precedence over set, and set has precedence over restore.
- R5: The take output is high only in a cycle where all of these hold: the boundary input is high, a request is present, the shadow flag is clear, and the request level is strictly greater than bits 1:0 of the priority register. An equal or lower level is not taken.
- R6: A take shifts the priority register left by two bits at the next clock edge and writes the request level into bits 1:0.
- R7: A privileged instruction retires. The shadow flag then becomes 1, and a request at the following boundary is not taken, whatever its level.
- R8: Any non-privileged instruction retiring clears the shadow flag. A privileged instruction retiring while the shadow is set keeps it set, so a run of privileged instructions extends the protection.
- R9: Operation strobes seen in a cycle without a retire pulse have no effect on the priority register or on the shadow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_i | input | 1 | An instruction completes this cycle |
| priv_i | input | 1 | The retiring instruction is privileged |
| set_i | input | 1 | Retiring instruction pushes a new level |
| set_lvl_i | input | 2 | Level pushed by a set |
| restore_i | input | 1 | Retiring instruction restores the previous level |
| load_i | input | 1 | Retiring instruction loads the register from a popped byte |
| reti_i | input | 1 | Retiring return-from-interrupt pops the register |
| pop_byte_i | input | 8 | Byte popped from the memory stack |
| boundary_i | input | 1 | The CPU is between instructions and may accept an interrupt |
| irq_req_i | input | 1 | An interrupt request is pending |
| irq_lvl_i | input | 2 | Level of the pending request |
| irq_take_o | output | 1 | Pulse: the pending request is accepted this cycle |
| cur_lvl_o | output | 2 | Current priority level (bits 1:0) |
| prio_o | output | 8 | Whole priority register |
| shadow_o | output | 1 | Interrupt shadow in force |

## Verification
Three pushes of different levels are followed by two restores. This shows whether the shift and rotate move the right pairs and whether wrap-around sends the low pair to the top. Requests at, below and above the current level, with and without the boundary strobe, show whether the comparison is strict and whether it is gated by the boundary. Runs of privileged retires of different lengths, each followed by a request at level 3, show whether the shadow is set, extended and then cleared. Strobes presented without a retire pulse show whether the operations are gated by retirement.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int LVL_W_DEF = 2;
   localparam int DEPTH_DEF = 4;

   typedef enum logic [1:0] {
      POP_NONE    = 2'd0,
      POP_PUSH    = 2'd1,
      POP_ROTATE  = 2'd2,
      POP_REPLACE = 2'd3
   } prio_op_e;
endpackage

// File: rtl/prio_stack.sv
module prio_stack
   import irq_prio_pkg::*;
#(
   parameter int LVL_W = 2,
   parameter int DEPTH = 4,
   localparam int REG_W = LVL_W * DEPTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take_push,
   input  logic [LVL_W-1:0] take_lvl,
   input  prio_op_e         op,
   input  logic [LVL_W-1:0] op_lvl,
   input  logic [REG_W-1:0] pop_byte,
   output logic [REG_W-1:0] prio_q
);
   logic [LVL_W-1:0] ins_lvl;
   logic [REG_W-1:0] shl_v;
   logic [REG_W-1:0] rot_v;
   logic [REG_W-1:0] prio_d;

   if (LVL_W < 1) begin : g_bad_lvl
      $error("prio_stack: LVL_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("prio_stack: DEPTH must be at least 2");
   end

   assign ins_lvl = take_push ? take_lvl : op_lvl;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_low
         assign shl_v[LVL_W-1:0] = ins_lvl;
      end else begin : g_up
         assign shl_v[g*LVL_W +: LVL_W] = prio_q[(g-1)*LVL_W +: LVL_W];
      end
      if (g == DEPTH-1) begin : g_top
         assign rot_v[g*LVL_W +: LVL_W] = prio_q[LVL_W-1:0];
      end else begin : g_mid
         assign rot_v[g*LVL_W +: LVL_W] = prio_q[(g+1)*LVL_W +: LVL_W];
      end
   end

   always_comb begin
      prio_d = prio_q;
      if (take_push) begin
         prio_d = shl_v;
      end else begin
         unique case (op)
            POP_PUSH:    prio_d = shl_v;
            POP_ROTATE:  prio_d = rot_v;
            POP_REPLACE: prio_d = pop_byte;
            default:     prio_d = prio_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prio_q <= '0;
      else     prio_q <= prio_d;
   end

   // R1: reset clears the stack
   a_r1_reset_clear: assert property (@(posedge clk) rst |=> prio_q == '0);
   // R6: accepted request pushed
   a_r6_take_push: assert property (@(posedge clk) disable iff (rst)
      take_push |=> (prio_q[LVL_W-1:0] == $past(take_lvl)) &&
                    (prio_q[REG_W-1:LVL_W] == $past(prio_q[REG_W-LVL_W-1:0])));
   // R2: set pushes operand level
   a_r2_set_push: assert property (@(posedge clk) disable iff (rst)
      (!take_push && op == POP_PUSH) |=> (prio_q[LVL_W-1:0] == $past(op_lvl)) &&
                    (prio_q[REG_W-1:LVL_W] == $past(prio_q[REG_W-LVL_W-1:0])));
   // R3: restore rotates right by one slot
   a_r3_restore_rot: assert property (@(posedge clk) disable iff (rst)
      (!take_push && op == POP_ROTATE) |=>
         (prio_q[REG_W-1 -: LVL_W] == $past(prio_q[LVL_W-1:0])) &&
         (prio_q[REG_W-LVL_W-1:0] == $past(prio_q[REG_W-1:LVL_W])));
   // R4: pop replaces whole register
   a_r4_pop_load: assert property (@(posedge clk) disable iff (rst)
      (!take_push && op == POP_REPLACE) |=> prio_q == $past(pop_byte));
   // R9: idle keeps register
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!take_push && op == POP_NONE) |=> $stable(prio_q));
endmodule

// File: rtl/shadow_ctl.sv
module shadow_ctl (
   input  logic clk,
   input  logic rst,
   input  logic retire,
   input  logic priv,
   output logic shadow_q
);
   always_ff @(posedge clk) begin
      if (rst)         shadow_q <= 1'b0;
      else if (retire) shadow_q <= priv;
   end

   // R7: privileged retire raises shadow
   a_r7_priv_sets: assert property (@(posedge clk) disable iff (rst)
      (retire && priv) |=> shadow_q);
   // R8: ordinary retire clears shadow
   a_r8_plain_clears: assert property (@(posedge clk) disable iff (rst)
      (retire && !priv) |=> !shadow_q);
   // R9: no retire, no change
   a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
      !retire |=> $stable(shadow_q));
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
   parameter int LVL_W = 2,
   parameter bit STRICT = 1'b1
) (
   input  logic             boundary,
   input  logic             shadow,
   input  logic             req,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic [LVL_W-1:0] cur_lvl,
   output logic             take
);
   logic above;

   if (STRICT) begin : g_strict
      assign above = req_lvl > cur_lvl;
   end else begin : g_loose
      assign above = req_lvl >= cur_lvl;
   end

   assign take = boundary && !shadow && req && above;

   always_comb begin
      // R7: nothing accepted while the shadow is in force
      a_r7_no_take_shadow: assert (!(take && shadow));
      // R5: acceptance only at a boundary with a request
      a_r5_take_gated: assert (!take || (boundary && req));
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int LVL_W = LVL_W_DEF,
   parameter int DEPTH = DEPTH_DEF,
   localparam int REG_W = LVL_W * DEPTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             retire_i,
   input  logic             priv_i,
   input  logic             set_i,
   input  logic [LVL_W-1:0] set_lvl_i,
   input  logic             restore_i,
   input  logic             load_i,
   input  logic             reti_i,
   input  logic [REG_W-1:0] pop_byte_i,
   input  logic             boundary_i,
   input  logic             irq_req_i,
   input  logic [LVL_W-1:0] irq_lvl_i,
   output logic             irq_take_o,
   output logic [LVL_W-1:0] cur_lvl_o,
   output logic [REG_W-1:0] prio_o,
   output logic             shadow_o
);
   prio_op_e op;
   logic     take;
   logic     shadow;
   logic [REG_W-1:0] prio_q;

   always_comb begin
      op = POP_NONE;
      if (retire_i) begin
         if (load_i || reti_i) op = POP_REPLACE;
         else if (set_i)       op = POP_PUSH;
         else if (restore_i)   op = POP_ROTATE;
      end
   end

   prio_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst       (rst),
      .take_push (take),
      .take_lvl  (irq_lvl_i),
      .op        (op),
      .op_lvl    (set_lvl_i),
      .pop_byte  (pop_byte_i),
      .prio_q    (prio_q)
   );

   shadow_ctl u_shadow (
      .clk      (clk),
      .rst      (rst),
      .retire   (retire_i),
      .priv     (priv_i),
      .shadow_q (shadow)
   );

   prio_arbiter #(.LVL_W(LVL_W), .STRICT(1'b1)) u_arb (
      .boundary (boundary_i),
      .shadow   (shadow),
      .req      (irq_req_i),
      .req_lvl  (irq_lvl_i),
      .cur_lvl  (prio_q[LVL_W-1:0]),
      .take     (take)
   );

   assign irq_take_o = take && !rst;
   assign cur_lvl_o  = prio_q[LVL_W-1:0];
   assign prio_o     = prio_q;
   assign shadow_o   = shadow;

   // R5: accepted level beats the current one
   a_r5_strictly_above: assert property (@(posedge clk) disable iff (rst)
      irq_take_o |-> irq_lvl_i > cur_lvl_o);
   // R1: reset quiets acceptance
   a_r1_no_take_reset: assert property (@(posedge clk) rst |-> !irq_take_o);
   // R7: after a privileged retire, the next boundary is closed
   a_r7_shadow_blocks: assert property (@(posedge clk) disable iff (rst)
      (retire_i && priv_i) |=> !irq_take_o);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst, retire_i, priv_i, set_i, restore_i, load_i, reti_i;
   logic       boundary_i, irq_req_i;
   logic [1:0] set_lvl_i, irq_lvl_i;
   logic [7:0] pop_byte_i;
   logic       irq_take_o, shadow_o;
   logic [1:0] cur_lvl_o;
   logic [7:0] prio_o;

   irq_prio_ctrl dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [7:0] prio;
      logic       sh;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   int         n_run = 0, n_fail = 0;
   logic [7:0] m_prio = 8'h00;
   logic       m_sh = 1'b0;
   bit         m_valid = 0;
   bit         done = 0;

   // monitor: compare registered state after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (prio_o !== e.prio || shadow_o !== e.sh) begin
               n_fail++;
               $display("FAIL %s: prio=%h shadow=%b expected prio=%h shadow=%b",
                        e.tag, prio_o, shadow_o, e.prio, e.sh);
            end
         end
      end
   end

   // op: 0 none, 1 set, 2 restore, 3 load, 4 reti
   task automatic step(input bit r, input bit ret, input bit pr, input int op,
                       input logic [7:0] arg, input bit bnd, input bit rq,
                       input logic [1:0] lv, input string tag);
      logic exp_take;
      exp_t e;
      @(negedge clk);
      rst = r; retire_i = ret; priv_i = pr;
      set_i = (op == 1); restore_i = (op == 2); load_i = (op == 3); reti_i = (op == 4);
      set_lvl_i = arg[1:0]; pop_byte_i = arg;
      boundary_i = bnd; irq_req_i = rq; irq_lvl_i = lv;
      #1;
      exp_take = !r && bnd && rq && !m_sh && (lv > m_prio[1:0]);
      n_run++;
      if (irq_take_o !== exp_take) begin
         n_fail++;
         $display("FAIL %s: take=%b expected %b", tag, irq_take_o, exp_take);
      end
      if (m_valid) begin
         n_run++;
         if (cur_lvl_o !== m_prio[1:0]) begin
            n_fail++;
            $display("FAIL %s: cur_lvl=%0d expected %0d", tag, cur_lvl_o, m_prio[1:0]);
         end
      end
      if (r) begin
         m_prio = 8'h00; m_sh = 1'b0; m_valid = 1;
      end else if (exp_take) begin
         m_prio = {m_prio[5:0], lv};
      end else if (ret) begin
         if (op == 3 || op == 4) m_prio = arg;
         else if (op == 1)       m_prio = {m_prio[5:0], arg[1:0]};
         else if (op == 2)       m_prio = {m_prio[1:0], m_prio[7:2]};
      end
      if (!r && ret) m_sh = pr;
      e.prio = m_prio; e.sh = m_sh; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin
      fork
         begin
            // R1 reset
            step(1,0,0,0,8'h00,0,0,2'd0,"R1 reset");
            step(1,1,1,1,8'h03,0,1,2'd3,"R1 reset holds");
            // R2 pushes
            step(0,1,0,1,8'h01,0,0,2'd0,"R2 set 1");
            step(0,1,0,1,8'h02,0,0,2'd0,"R2 set 2");
            step(0,1,0,1,8'h03,0,0,2'd0,"R2 set 3");
            // R3 rotates
            step(0,1,0,2,8'h00,0,0,2'd0,"R3 restore");
            step(0,1,0,2,8'h00,0,0,2'd0,"R3 restore twice");
            // R9 strobes without retire
            step(0,0,1,1,8'h02,0,0,2'd0,"R9 set w/o retire");
            step(0,0,0,3,8'hFF,0,0,2'd0,"R9 load w/o retire");
            // R4 loads and precedence
            step(0,1,0,3,8'h5A,0,0,2'd0,"R4 load");
            step(0,1,0,4,8'h03,0,0,2'd0,"R4 reti");
            // R5 equal level not taken, no boundary not taken
            step(0,0,0,0,8'h00,1,1,2'd3,"R5 equal level");
            step(0,1,0,3,8'h01,0,0,2'd0,"R4 load 01");
            step(0,0,0,0,8'h00,0,1,2'd3,"R5 no boundary");
            step(0,0,0,0,8'h00,1,1,2'd0,"R5 lower level");
            // R6 accepted request pushes
            step(0,0,0,0,8'h00,1,1,2'd2,"R6 take lvl 2");
            step(0,0,0,0,8'h00,1,1,2'd3,"R6 take lvl 3");
            step(0,1,0,4,8'h00,0,0,2'd0,"R4 reti to 0");
            // R7 shadow after privileged retire
            step(0,1,1,0,8'h00,0,0,2'd0,"R7 priv retire");
            step(0,0,0,0,8'h00,1,1,2'd3,"R7 boundary blocked");
            // R8 run of privileged extends
            step(0,1,1,0,8'h00,0,0,2'd0,"R8 priv again");
            step(0,0,0,0,8'h00,1,1,2'd3,"R8 still blocked");
            step(0,1,0,0,8'h00,0,0,2'd0,"R8 plain retire clears");
            step(0,0,0,0,8'h00,1,1,2'd3,"R8 take after clear");
            // R9 shadow unchanged without retire
            step(0,1,1,0,8'h00,0,0,2'd0,"R9 priv retire");
            step(0,0,0,0,8'h00,0,0,2'd0,"R9 shadow holds");
            step(0,0,0,0,8'h00,0,0,2'd0,"R9 idle");
            repeat (3) @(posedge clk);
            done = 1;
         end
         begin
            repeat (2000) @(posedge clk);
            if (!done) begin
               n_run++;
               n_fail++;
               $display("FAIL watchdog: run hung, expected completion");
            end
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule